// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a cartridge interrupt request after a programmed number of rendered video scanlines. The CPU programs it with four register writes: one loads an 8-bit down-counter directly, one loads an 8-bit reload value, one switches counting off and withdraws the request, and one switches counting on. An external video timing source supplies a one-cycle pulse per scanline, together with that line's number and a flag saying whether rendering is active. The block does not detect scanlines itself and does no bank mapping.

On every qualifying scanline the counter steps down by one. When the result is zero, the counter takes the reload value and the interrupt request is raised. The request is a level and stays high until software turns counting off. A small state machine holds the enable flag and the pending request. It has three states. `ST_OFF` means counting is stopped and no request is pending. `ST_RUN` means counting with no request pending. `ST_FIRED` means counting with a request pending. The transitions are: `ST_OFF` to `ST_RUN` on an enable write; `ST_RUN` to `ST_FIRED` when the counter reaches zero; `ST_RUN` or `ST_FIRED` to `ST_OFF` on a disable write. An enable write in `ST_FIRED` leaves the state unchanged.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write whose address gives 0xC000 after masking with 0xE001 loads the data byte into the counter.
- R2: A write whose masked address is 0xC001 loads the data byte into the reload register and leaves the counter unchanged.
- R3: A write whose masked address is 0xE000 turns counting off and drops `irq` in the following cycle. While counting is off, scanlines change nothing.
- R4: A write whose masked address is 0xE001 turns counting on and leaves a pending `irq` high.
- R5: A scanline pulse counts only when `line_num` is between 0 and 239 inclusive, `render_en` is high and counting is on.
- R6: A counting scanline first decrements the counter. If the result is zero, the counter reloads from the reload register and `irq` rises one cycle after the pulse. A counter value N therefore fires on the Nth counting scanline, and a value of 0 fires on the 256th.
- R7: `irq` is a level. Once raised, it stays high through further scanlines and counter or reload writes, until a disable write or a reset.
- R8: After reset the counter and reload register are 0, counting is off and `irq` is low.
- R9: When a counter write and a counting scanline fall in the same cycle, the write wins. The scanline is lost and `irq` does not rise.
- R10: Only address bits 15, 14, 13 and 0 are decoded. All other masked addresses, such as 0x8001 or 0xA000, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the scanline being signalled |
| render_en | input | 1 | High while rendering is enabled |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The checker runs on every cycle. It checks the register loads (R1, R2), that the counter holds when no scanline counts, the reload and rise of `irq` when the count runs out, that a disable clears the request, and that a pending request survives enable and counter writes. Some behaviours need a whole scenario to show, and only the bench covers them. These are the exact scanline on which `irq` fires for a sweep of start and reload values, the 256-line wrap from 0, the boundary line numbers, and the address mirrors. The bench observes all of them purely through the timing of `irq`.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FIRED = 2'd2
    } sirq_state_e;

    localparam logic [15:0] DEC_MASK   = 16'hE001;
    localparam logic [15:0] ADR_COUNT  = 16'hC000;
    localparam logic [15:0] ADR_RELOAD = 16'hC001;
    localparam logic [15:0] ADR_STOP   = 16'hE000;
    localparam logic [15:0] ADR_START  = 16'hE001;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ld_cnt,
    output logic              ld_latch,
    output logic              stop,
    output logic              start
);
    localparam int NSEL = 4;

    logic [ADDR_W-1:0] masked;
    logic [NSEL-1:0]   hit;
    logic [15:0]       targets [NSEL];

    assign targets[0] = ADR_COUNT;
    assign targets[1] = ADR_RELOAD;
    assign targets[2] = ADR_STOP;
    assign targets[3] = ADR_START;

    assign masked = wr_addr & DEC_MASK[ADDR_W-1:0];

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign hit[g] = wr_en && (masked == targets[g][ADDR_W-1:0]);
    end

    assign ld_cnt   = hit[0];
    assign ld_latch = hit[1];
    assign stop     = hit[2];
    assign start    = hit[3];

endmodule

// File: rtl/sirq_count.sv
module sirq_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_cnt,
    input  logic             ld_latch,
    input  logic [CNT_W-1:0] data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] latch,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, latch_q, dec;

    always_comb begin
        dec  = cnt_q - ONE;
        fire = tick && !ld_cnt && (dec == ZERO);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= ZERO;
            latch_q <= ZERO;
        end else begin
            if (ld_latch) begin
                latch_q <= data;
            end
            if (ld_cnt) begin
                cnt_q <= data;
            end else if (tick) begin
                cnt_q <= fire ? latch_q : dec;
            end
        end
    end

    assign cnt   = cnt_q;
    assign latch = latch_q;

endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic start,
    input  logic fire,
    output logic enabled,
    output logic irq
);
    sirq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (stop)      state_d = ST_OFF;
                else if (fire) state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (stop) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        enabled = (state_q == ST_RUN) || (state_q == ST_FIRED);
        irq     = (state_q == ST_FIRED);
    end

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 8,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    output logic              irq
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

    logic             ld_cnt_w, ld_latch_w, stop_w, start_w;
    logic             enabled_w, fire_w, tick_w;
    logic [CNT_W-1:0] cnt_w, latch_w;

    sirq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .ld_cnt   (ld_cnt_w),
        .ld_latch (ld_latch_w),
        .stop     (stop_w),
        .start    (start_w)
    );

    assign tick_w = line_pulse && render_en && (line_num <= LAST) && enabled_w;

    sirq_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .ld_cnt   (ld_cnt_w),
        .ld_latch (ld_latch_w),
        .data     (wr_data),
        .cnt      (cnt_w),
        .latch    (latch_w),
        .fire     (fire_w)
    );

    sirq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop    (stop_w),
        .start   (start_w),
        .fire    (fire_w),
        .enabled (enabled_w),
        .irq     (irq)
    );

endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             tick,
    input logic             ld_cnt,
    input logic             ld_latch,
    input logic             stop,
    input logic             start,
    input logic [CNT_W-1:0] data,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] latch
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_cnt_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt |=> cnt == $past(data));

    p_reload_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_latch && !tick) |=> (latch == $past(data)) && (cnt == $past(cnt)));

    p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !irq);

    p_start_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && irq) |=> irq);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_cnt) |=> cnt == $past(cnt));

    p_fire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_cnt && cnt == ONE && !stop) |=> irq && (cnt == $past(latch)));

    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stop) |=> irq);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cnt && !irq) |=> !irq);

endmodule

bind scanline_irq_counter sirq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .tick     (tick_w),
    .ld_cnt   (ld_cnt_w),
    .ld_latch (ld_latch_w),
    .stop     (stop_w),
    .start    (start_w),
    .data     (wr_data),
    .cnt      (cnt_w),
    .latch    (latch_w)
);

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_pulse = 1'b0;
    logic [8:0]  line_num = '0;
    logic        render_en = 1'b0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    scanline_irq_counter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_pulse(line_pulse), .line_num(line_num),
        .render_en(render_en), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic line(input int ln, input logic ren);
        @(negedge clk);
        line_pulse = 1'b1; line_num = ln[8:0]; render_en = ren;
        @(negedge clk);
        line_pulse = 1'b0;
    endtask

    task automatic count_fire(input int maxn, output int k);
        k = 0;
        for (int i = 1; i <= maxn; i++) begin
            line(i % 240, 1'b1);
            if (irq) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic run_one(input int L);
        int k;
        int exp;
        exp = (L == 0) ? 256 : L;
        wr(16'hC000, L[7:0]);
        wr(16'hC001, L[7:0]);
        wr(16'hE001, 8'h00);
        count_fire(300, k);
        chk($sformatf("R1 R6 first fire L=%0d", L), k, exp);
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);
        count_fire(300, k);
        chk($sformatf("R6 reload fire L=%0d", L), k, exp);
        wr(16'hE000, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog R6 actual=%0d cycles expected=150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 irq low after reset", irq, 0);

        // R8: counter resets to 0, so the first fire needs 256 lines
        wr(16'hE001, 8'h00);
        count_fire(300, k);
        chk("R8 reset counter wraps to 256", k, 256);
        wr(16'hE000, 8'h00);
        chk("R3 stop clears irq", irq, 0);

        for (int L = 0; L <= 32; L++) run_one(L);
        run_one(64);
        run_one(127);
        run_one(128);
        run_one(200);
        run_one(255);

        // R2: reload write leaves the running counter alone
        wr(16'hC000, 8'd5);
        wr(16'hC001, 8'd9);
        wr(16'hE001, 8'h00);
        count_fire(300, k);
        chk("R2 counter kept after reload write", k, 5);
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);
        count_fire(300, k);
        chk("R2 reload value used", k, 9);

        // R4 and R7: pending request survives
        wr(16'hE001, 8'h00);
        chk("R4 start keeps pending irq", irq, 1);
        wr(16'hC000, 8'd3);
        wr(16'hC001, 8'd7);
        for (int i = 0; i < 10; i++) line(20 + i, 1'b1);
        chk("R7 irq held through lines and writes", irq, 1);

        // R3: stopped block ignores scanlines
        wr(16'hE000, 8'h00);
        chk("R3 irq dropped", irq, 0);
        wr(16'hC000, 8'd1);
        for (int i = 0; i < 3; i++) line(5, 1'b1);
        chk("R3 no count while stopped", irq, 0);

        // R5: qualification of scanlines
        wr(16'hE001, 8'h00);
        line(240, 1'b1);
        chk("R5 line 240 ignored", irq, 0);
        line(261, 1'b1);
        chk("R5 line 261 ignored", irq, 0);
        line(50, 1'b0);
        chk("R5 rendering off ignored", irq, 0);
        line(239, 1'b1);
        chk("R5 line 239 counts", irq, 1);
        wr(16'hE000, 8'h00);
        wr(16'hC000, 8'd1);
        wr(16'hE001, 8'h00);
        line(0, 1'b1);
        chk("R5 line 0 counts", irq, 1);

        // R9: counter write wins over a same-cycle scanline
        wr(16'hE000, 8'h00);
        wr(16'hC000, 8'd1);
        wr(16'hC001, 8'd50);
        wr(16'hE001, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'hC000; wr_data = 8'd3;
        line_pulse = 1'b1; line_num = 9'd10; render_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; line_pulse = 1'b0;
        chk("R9 collided line does not fire", irq, 0);
        count_fire(300, k);
        chk("R9 written value counted", k, 3);

        // R10: decode mirrors and ignored addresses
        wr(16'hFFFE, 8'h00);
        chk("R10 mirror of stop", irq, 0);
        wr(16'hDFFE, 8'd2);
        wr(16'hC003, 8'd4);
        wr(16'h8001, 8'd9);
        wr(16'hA000, 8'd9);
        wr(16'h4000, 8'd9);
        wr(16'hE7FF, 8'h00);
        count_fire(300, k);
        chk("R10 mirrored counter write", k, 2);
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);
        count_fire(300, k);
        chk("R10 mirrored reload write", k, 4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule